// File: doc/BRIEF.md
# Fixed-Point DSP Arithmetic Unit

This block is the integer arithmetic stage of a DSP datapath. Each cycle it can accept one operation on two 32-bit two's-complement operands, X and Y, and a single carry-in bit. It computes the result combinationally and captures it in output registers. It also captures four status flags: zero, negative, signed overflow and carry. One operation code computes both the sum and the difference of the same pair of operands, and returns them on two result outputs.

The operation set has plain and carry-biased addition and subtraction, unary carry, increment and decrement forms, and a midpoint average that never overflows. It also has a compare that changes only the flags, plus negate, absolute value, pass, signed minimum and maximum, clipping to a symmetric bound, and four bitwise operations. An upstream sequencer drives the operation code together with a valid strobe. Downstream logic reads the registered results one clock edge later.

Top module: `dsp_fx_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, `valid_o`, both results and all four flags are cleared to zero on that edge.
- R2: Results and flags are captured on the rising edge where `valid_i` is high, and `valid_o` is high for the following cycle. With `valid_i` low, results and flags hold their values and `valid_o` falls.
- R3: ADD (op 0) gives X+Y. SUB (op 1) gives X-Y. ADDC (op 2) gives X+Y+CI. SUBB (op 3) gives X-Y+CI-1. For the subtract forms the carry flag is the carry out of X + ~Y + carry-term, so it is 1 when no borrow occurs.
- R4: DUAL (op 4) gives X+Y on `result_o` and X-Y on `result2_o`, with the flags taken from the sum. Every other operation that writes a result writes zero to `result2_o`.
- R5: XCI (op 13) gives X+CI, XCIM (op 14) gives X+CI-1, INC (op 15) gives X+1 and DEC (op 16) gives X-1. Each sets carry and overflow from that addition.
- R6: AVG (op 5) gives the 33-bit signed sum X+Y shifted right arithmetically by one. It clears overflow and carry.
- R7: CMP (op 6) sets the flags as for X-Y. It leaves `result_o` and `result2_o` unchanged.
- R8: NEG (op 7) gives -X and ABS (op 8) gives |X|. Both clear the carry flag. When X is 0x80000000 both return 0x80000000 and set the overflow flag.
- R9: MIN (op 10) and MAX (op 11) return the signed smaller or larger of X and Y. PASS (op 9) returns X. All three clear overflow and carry.
- R10: CLIP (op 12) returns +|Y| when X exceeds +|Y|, returns -|Y| when X is below -|Y|, and returns X otherwise. The magnitude of Y is formed with 33 bits, so Y = 0x80000000 leaves every X unchanged.
- R11: AND (op 17), OR (op 18) and XOR (op 19) combine X and Y bit by bit. NOT (op 20) inverts X. All four clear overflow and carry.
- R12: The zero flag is set when the computed value is zero, and the negative flag copies bit 31 of that value. For CMP the computed value is X-Y. For the adding operations, the overflow flag marks a signed overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 5 | Operation code |
| x_i | input | 32 | Operand X |
| y_i | input | 32 | Operand Y |
| ci_i | input | 1 | Carry input |
| valid_o | output | 1 | Registered results are fresh |
| result_o | output | 32 | Primary result |
| result2_o | output | 32 | Difference output of DUAL |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Signed overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The assertions assume that `op_i`, `x_i` and `y_i` are stable and known whenever `valid_i` is high at an edge. They also assume that `op_i` only carries the codes 0 to 20. The relation between the two results and the flag checks are tied to the operation captured with the last valid strobe. The stimulus drives every input on the falling edge, holds `valid_i` for exactly one rising edge per operation, and uses only defined codes. Reset is held across the first edges, before any operation.

// File: rtl/dsp_alu_pkg.sv
// Package: shared operation codes for the fixed-point arithmetic unit.
// Assumes a 5-bit operation field; codes 21..31 are unused.
package dsp_alu_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_ADDC  = 5'd2,
        OP_SUBB  = 5'd3,
        OP_DUAL  = 5'd4,
        OP_AVG   = 5'd5,
        OP_CMP   = 5'd6,
        OP_NEG   = 5'd7,
        OP_ABS   = 5'd8,
        OP_PASS  = 5'd9,
        OP_MIN   = 5'd10,
        OP_MAX   = 5'd11,
        OP_CLIP  = 5'd12,
        OP_XCI   = 5'd13,
        OP_XCIM  = 5'd14,
        OP_INC   = 5'd15,
        OP_DEC   = 5'd16,
        OP_AND   = 5'd17,
        OP_OR    = 5'd18,
        OP_XOR   = 5'd19,
        OP_NOT   = 5'd20
    } alu_op_e;
endpackage

// File: rtl/dsp_alu_operands.sv
// Module: selects the three adder inputs (a, b, carry) for every adding
// operation so a single adder serves the whole add/subtract family.
// Assumes subtraction is done as a + ~b + carry.
module dsp_alu_operands
    import dsp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  y,
    input  logic          ci,
    output logic [W-1:0]  a,
    output logic [W-1:0]  b,
    output logic          c
);
    // Operand routing per operation code.
    always_comb begin
        a = x;
        b = y;
        c = 1'b0;
        unique case (op)
            OP_ADD, OP_DUAL:  begin b = y;         c = 1'b0; end
            OP_ADDC:          begin b = y;         c = ci;   end
            OP_SUB, OP_CMP:   begin b = ~y;        c = 1'b1; end
            OP_SUBB:          begin b = ~y;        c = ci;   end
            OP_XCI:           begin b = '0;        c = ci;   end
            OP_XCIM:          begin b = '1;        c = ci;   end
            OP_INC:           begin b = '0;        c = 1'b1; end
            OP_DEC:           begin b = '1;        c = 1'b0; end
            OP_NEG, OP_ABS:   begin a = '0; b = ~x; c = 1'b1; end
            default:          begin a = x; b = y;  c = 1'b0; end
        endcase
    end
endmodule

// File: rtl/dsp_alu_adder.sv
// Module: W-bit adder with carry in, carry out and signed overflow.
// Assumes two's-complement operands.
module dsp_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    // Sum with carry out, overflow when same-signed inputs change sign.
    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
        ovf  = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/dsp_alu_misc.sv
// Module: non-adding results: average, pass, min/max, clip and bitwise logic.
// Assumes signed two's-complement operands; clip bound is |y| in W+1 bits.
module dsp_alu_misc
    import dsp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res
);
    localparam int WE = W + 1;

    logic signed [WE-1:0] xs, ys, mag, nmag, sum_e;
    logic [W-1:0] clip_r;
    logic         x_lt_y;

    // Widened operands, midpoint sum and the symmetric clip bound.
    always_comb begin
        xs     = $signed({x[W-1], x});
        ys     = $signed({y[W-1], y});
        sum_e  = xs + ys;
        mag    = ys[WE-1] ? -ys : ys;
        nmag   = -mag;
        x_lt_y = $signed(x) < $signed(y);
        if (xs > mag)       clip_r = mag[W-1:0];
        else if (xs < nmag) clip_r = nmag[W-1:0];
        else                clip_r = x;
    end

    // Result select for the non-adding operations.
    always_comb begin
        unique case (op)
            OP_AVG:  res = sum_e[WE-1:1];
            OP_MIN:  res = x_lt_y ? x : y;
            OP_MAX:  res = x_lt_y ? y : x;
            OP_CLIP: res = clip_r;
            OP_AND:  res = x & y;
            OP_OR:   res = x | y;
            OP_XOR:  res = x ^ y;
            OP_NOT:  res = ~x;
            default: res = x;
        endcase
    end
endmodule

// File: rtl/dsp_fx_alu.sv
// Module: top of the fixed-point arithmetic unit. Combines one shared adder,
// a dedicated difference adder for the dual operation and the non-adding
// unit, then registers results and flags on a valid strobe.
// Assumes op_i holds a defined code whenever valid_i is high.
module dsp_fx_alu
    import dsp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    x_i,
    input  logic [W-1:0]    y_i,
    input  logic            ci_i,
    output logic            valid_o,
    output logic [W-1:0]    result_o,
    output logic [W-1:0]    result2_o,
    output logic            flag_z_o,
    output logic            flag_n_o,
    output logic            flag_v_o,
    output logic            flag_c_o
);
    alu_op_e      op;
    alu_op_e      op_q;
    logic [W-1:0] add_a, add_b, add_s, dif_s, misc_r;
    logic         add_c, add_co, add_ov, dif_co, dif_ov;
    logic [W-1:0] res_n, res2_n;
    logic         z_n, n_n, v_n, c_n, adding;

    assign op = alu_op_e'(op_i);

    dsp_alu_operands #(.W(W)) u_opnd (
        .op(op), .x(x_i), .y(y_i), .ci(ci_i),
        .a(add_a), .b(add_b), .c(add_c)
    );

    dsp_alu_adder #(.W(W)) u_main_add (
        .a(add_a), .b(add_b), .cin(add_c),
        .sum(add_s), .cout(add_co), .ovf(add_ov)
    );

    dsp_alu_adder #(.W(W)) u_diff_add (
        .a(x_i), .b(~y_i), .cin(1'b1),
        .sum(dif_s), .cout(dif_co), .ovf(dif_ov)
    );

    dsp_alu_misc #(.W(W)) u_misc (
        .op(op), .x(x_i), .y(y_i), .res(misc_r)
    );

    // Result choice and flag rules per operation.
    always_comb begin
        adding = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_ADDC, OP_SUBB, OP_DUAL, OP_CMP,
            OP_XCI, OP_XCIM, OP_INC, OP_DEC: adding = 1'b1;
            default: adding = 1'b0;
        endcase
        if (adding || op == OP_NEG) res_n = add_s;
        else if (op == OP_ABS)      res_n = x_i[W-1] ? add_s : x_i;
        else                        res_n = misc_r;
        res2_n = (op == OP_DUAL) ? dif_s : '0;
        z_n    = (res_n == '0);
        n_n    = res_n[W-1];
        if (adding || op == OP_NEG) v_n = add_ov;
        else if (op == OP_ABS)      v_n = x_i[W-1] & add_ov;
        else                        v_n = 1'b0;
        c_n    = adding & add_co;
    end

    // Output registers: flags on every valid op, results except on compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            result_o  <= '0;
            result2_o <= '0;
            flag_z_o  <= 1'b0;
            flag_n_o  <= 1'b0;
            flag_v_o  <= 1'b0;
            flag_c_o  <= 1'b0;
            op_q      <= OP_ADD;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                op_q     <= op;
                flag_z_o <= z_n;
                flag_n_o <= n_n;
                flag_v_o <= v_n;
                flag_c_o <= c_n;
                if (op != OP_CMP) begin
                    result_o  <= res_n;
                    result2_o <= res2_n;
                end
            end
        end
    end

    // R1: reset clears the output stage.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && result_o == '0 && result2_o == '0));

    // R2: without a strobe the outputs hold.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(result_o) && $stable(flag_z_o) && $stable(flag_c_o)));

    // R7: compare leaves the results untouched.
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_CMP) |=> ($stable(result_o) && $stable(result2_o)));

    // R4: sum minus difference equals twice the captured Y.
    a_r4_dual_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_DUAL) |=> ((result_o - result2_o) == ($past(y_i) << 1)));

    // R12: zero and negative flags agree with the written result.
    a_r12_zn_match: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && op_q != OP_CMP) |->
            (flag_z_o == (result_o == '0) && flag_n_o == result_o[W-1]));

    // R11: bitwise operations never raise overflow or carry.
    a_r11_logic_no_vc: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR || op_q == OP_NOT))
            |-> (!flag_v_o && !flag_c_o));
endmodule

// File: tb/test_dsp_fx_alu.sv
module test_dsp_fx_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] x_i = '0, y_i = '0;
    logic        ci_i = 1'b0;
    logic        valid_o;
    logic [31:0] result_o, result2_o;
    logic        flag_z_o, flag_n_o, flag_v_o, flag_c_o;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    localparam logic [31:0] MINV = 32'h8000_0000;
    localparam logic [31:0] MAXV = 32'h7fff_ffff;

    dsp_fx_alu i_dsp_fx_alu (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .x_i(x_i), .y_i(y_i), .ci_i(ci_i), .valid_o(valid_o),
        .result_o(result_o), .result2_o(result2_o),
        .flag_z_o(flag_z_o), .flag_n_o(flag_n_o),
        .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fl();
        return {28'd0, flag_z_o, flag_n_o, flag_v_o, flag_c_o};
    endfunction

    // One operation: strobe for one edge, then sample before the next edge.
    task automatic run(input logic [4:0] op, input logic [31:0] x, input logic [31:0] y,
                       input logic ci);
        @(negedge clk);
        op_i = op; x_i = x; y_i = y; ci_i = ci; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid", {31'd0, valid_o}, 0);
        chk("R1 result", result_o, 0);
        chk("R1 result2", result2_o, 0);
        chk("R1 flags", fl(), 0);
    endtask

    task automatic t_strobe();
        run(5'd0, 32'd5, 32'd7, 1'b0);
        chk("R2 valid_o high", {31'd0, valid_o}, 1);
        chk("R3 add", result_o, 32'd12);
        chk("R12 add flags", fl(), 4'b0000);
        @(negedge clk);
        chk("R2 valid_o low", {31'd0, valid_o}, 0);
        op_i = 5'd17; x_i = 0; y_i = 0;
        @(negedge clk);
        chk("R2 hold result", result_o, 32'd12);
        chk("R2 hold flags", fl(), 4'b0000);
    endtask

    task automatic t_add_family();
        run(5'd0, MAXV, 32'd1, 1'b0);
        chk("R12 add overflow", result_o, MINV);  chk("R12 add ovf flags", fl(), 4'b0110);
        run(5'd0, 32'hffff_ffff, 32'd1, 1'b0);
        chk("R12 add zero", result_o, 0);          chk("R12 add carry flags", fl(), 4'b1001);
        run(5'd1, 32'd5, 32'd7, 1'b0);
        chk("R3 sub", result_o, 32'hffff_fffe);    chk("R3 sub flags", fl(), 4'b0100);
        run(5'd2, 32'd5, 32'd7, 1'b1);
        chk("R3 addc", result_o, 32'd13);
        run(5'd3, 32'd10, 32'd3, 1'b0);
        chk("R3 subb ci0", result_o, 32'd6);       chk("R3 subb carry", fl(), 4'b0001);
        run(5'd3, 32'd10, 32'd3, 1'b1);
        chk("R3 subb ci1", result_o, 32'd7);
    endtask

    task automatic t_dual();
        run(5'd4, 32'd10, 32'd3, 1'b0);
        chk("R4 dual sum", result_o, 32'd13);
        chk("R4 dual diff", result2_o, 32'd7);
        chk("R4 dual flags", fl(), 4'b0000);
        run(5'd4, 32'd3, 32'd10, 1'b0);
        chk("R4 dual neg diff", result2_o, 32'hffff_fff9);
        run(5'd9, 32'd1, 32'd0, 1'b0);
        chk("R4 result2 zeroed", result2_o, 0);
    endtask

    task automatic t_unary();
        run(5'd13, 32'd5, 0, 1'b1);  chk("R5 xci", result_o, 32'd6);
        run(5'd14, 32'd5, 0, 1'b0);  chk("R5 xcim ci0", result_o, 32'd4);
        run(5'd14, 32'd5, 0, 1'b1);  chk("R5 xcim ci1", result_o, 32'd5);
        run(5'd15, MAXV, 0, 1'b0);   chk("R5 inc", result_o, MINV);
        chk("R5 inc flags", fl(), 4'b0110);
        run(5'd16, 32'd0, 0, 1'b0);  chk("R5 dec", result_o, 32'hffff_ffff);
        chk("R5 dec flags", fl(), 4'b0100);
        run(5'd16, 32'd1, 0, 1'b0);  chk("R5 dec to zero flags", fl(), 4'b1001);
    endtask

    task automatic t_avg();
        run(5'd5, MAXV, MAXV, 1'b0);  chk("R6 avg max", result_o, MAXV);
        chk("R6 avg flags", fl(), 4'b0000);
        run(5'd5, 32'hffff_fffd, 32'd0, 1'b0); chk("R6 avg neg", result_o, 32'hffff_fffe);
        run(5'd5, MINV, MINV, 1'b0);  chk("R6 avg min", result_o, MINV);
        chk("R6 avg min flags", fl(), 4'b0100);
    endtask

    task automatic t_cmp();
        run(5'd9, 32'h1234, 0, 1'b0);
        run(5'd6, 32'd5, 32'd5, 1'b0);
        chk("R7 cmp keeps result", result_o, 32'h1234);
        chk("R7 cmp keeps result2", result2_o, 0);
        chk("R7 cmp equal flags", fl(), 4'b1001);
        run(5'd6, 32'd3, 32'd5, 1'b0);
        chk("R7 cmp less flags", fl(), 4'b0100);
        chk("R7 cmp keeps result again", result_o, 32'h1234);
    endtask

    task automatic t_negabs();
        run(5'd7, 32'd5, 0, 1'b0);  chk("R8 neg", result_o, 32'hffff_fffb);
        run(5'd7, 32'd0, 0, 1'b0);  chk("R8 neg zero flags", fl(), 4'b1000);
        run(5'd7, MINV, 0, 1'b0);   chk("R8 neg min", result_o, MINV);
        chk("R8 neg min flags", fl(), 4'b0110);
        run(5'd8, 32'hffff_fff9, 0, 1'b0); chk("R8 abs", result_o, 32'd7);
        chk("R8 abs flags", fl(), 4'b0000);
        run(5'd8, 32'd9, 0, 1'b0);  chk("R8 abs pos", result_o, 32'd9);
        run(5'd8, MINV, 0, 1'b0);   chk("R8 abs min", result_o, MINV);
        chk("R8 abs min flags", fl(), 4'b0110);
    endtask

    task automatic t_minmax();
        run(5'd10, 32'hffff_ffff, 32'd1, 1'b0); chk("R9 min", result_o, 32'hffff_ffff);
        run(5'd11, 32'hffff_ffff, 32'd1, 1'b0); chk("R9 max", result_o, 32'd1);
        run(5'd10, MAXV, MINV, 1'b0);           chk("R9 min extreme", result_o, MINV);
        chk("R9 min flags", fl(), 4'b0100);
        run(5'd9, 32'habcd, 0, 1'b0);           chk("R9 pass", result_o, 32'habcd);
    endtask

    task automatic t_clip();
        run(5'd12, 32'd100, 32'hffff_ffce, 1'b0); chk("R10 clip high", result_o, 32'd50);
        run(5'd12, 32'hffff_ff9c, 32'd50, 1'b0);  chk("R10 clip low", result_o, 32'hffff_ffce);
        run(5'd12, 32'd20, 32'd50, 1'b0);         chk("R10 clip inside", result_o, 32'd20);
        run(5'd12, MINV, MINV, 1'b0);             chk("R10 clip min bound", result_o, MINV);
    endtask

    task automatic t_logic();
        run(5'd17, 32'hf0f0, 32'hff00, 1'b0); chk("R11 and", result_o, 32'hf000);
        run(5'd18, 32'hf0f0, 32'hff00, 1'b0); chk("R11 or", result_o, 32'hfff0);
        run(5'd19, 32'hf0f0, 32'hff00, 1'b0); chk("R11 xor", result_o, 32'h0ff0);
        run(5'd20, 32'd0, 32'd5, 1'b0);       chk("R11 not", result_o, 32'hffff_ffff);
        chk("R11 not flags", fl(), 4'b0100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_strobe();
        t_add_family();
        t_dual();
        t_unary();
        t_avg();
        t_cmp();
        t_negabs();
        t_minmax();
        t_clip();
        t_logic();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule